// File: doc/BRIEF.md
# Parity Path Replica for Delay Testing

This block is a delay-test copy of a near-critical logic path. A launch flop drives a transition into a chain of lookup stages. Each stage has been rewritten so that its output is the parity of its data inputs, inverted when its Edge control is high. On stages that share logic with another tested path, a Fix control can force the output high. Because parity passes every input change through, one rising or falling transition at the launch flop reaches the end of the path as long as no Fix is active upstream. Which way it arrives is set by the Edge controls.

A sink flop captures the end of the chain. When the test controller asserts a check strobe, the sink value is compared against the expected value with an equality (XNOR) test. A mismatch sets a sticky error flag, and only a synchronous clear resets it. The controller holds the off-path (side) inputs, Edge and Fix steady. It launches a transition, waits for the capture, strobes the check and then reads the flag. If the flag sets when the clock is raised or the supply is lowered, the path has a timing fault.

Top module: `path_replica`

## Requirements
- R1: While rst_ni is low, and right after it rises, sink_o and err_o are 0. The launch flop also resets to 0.
- R2: On each rising clock edge, launch_i is captured into the launch flop. That value feeds stage 0 as its on-path input.
- R3: Stage s computes p = in ^ side_i[s] ^ edge_i[s], where in is the launch flop for s = 0 and stage s-1 otherwise. With the default 4-input stages there is one side bit per stage, at side_i bit s. If stage s is fixable and fix_i[s] is 1, the output is forced to 1. Otherwise the output is p.
- R4: With no fixable stage fixed, inverting any single edge_i bit inverts sink_o one clock edge later.
- R5: While a fixable stage is fixed, changes on launch_i and on the side and edge bits of that stage and of every earlier stage have no effect on sink_o.
- R6: fix_i bits of stages not enabled in FIX_EN have no effect. The default FIX_EN is 3'b010, so only stage 1 is fixable.
- R7: sink_o takes the chain output on each rising edge. A launch_i change therefore shows on sink_o after the second rising edge, not after the first.
- R8: If check_i is 1 and sink_o differs from expect_i at a rising edge, err_o is 1 after that edge.
- R9: Once set, err_o stays 1 until cleared, even when later checks match.
- R10: clr_i at a rising edge makes err_o 0 after that edge. It takes priority over a mismatch in the same cycle.
- R11: err_o does not set when check_i is 0, or when sink_o equals expect_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Launch and capture clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| launch_i | input | 1 | Value captured by the launch flop |
| side_i | input | NUM_STAGES*(LUT_K-3) | Off-path data inputs, LUT_K-3 bits per stage, stage 0 lowest |
| edge_i | input | NUM_STAGES | Per-stage inversion control |
| fix_i | input | NUM_STAGES | Per-stage force-high control, used only where FIX_EN is set |
| check_i | input | 1 | Compare strobe |
| expect_i | input | 1 | Expected sink value |
| clr_i | input | 1 | Synchronous clear of the error flag |
| sink_o | output | 1 | Captured path output |
| err_o | output | 1 | Sticky timing-fault flag |

## Verification
On every cycle the assertions check the error flag: it sets on a strobed mismatch, it stays set, clear has priority, and it never sets on its own. They also check that a single Edge flip inverts the captured value, and that an active Fix freezes the capture. The exact parity function across all input combinations, the two-edge launch-to-capture latency, and the fact that Fix bits on non-fixable stages are ignored can only be shown by the bench scenarios, which compare against an independent model.

// File: rtl/path_replica_pkg.sv
package path_replica_pkg;
  // Output of one rewritten lookup stage
  function automatic logic stage_eval(input logic parity, input logic edge_c,
                                      input logic fix_c, input logic fixable);
    if (fixable && fix_c) return 1'b1;
    return parity ^ edge_c;
  endfunction
endpackage

// File: rtl/replica_launch.sv
module replica_launch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/replica_stage.sv
module replica_stage
  import path_replica_pkg::*;
#(
  parameter int unsigned SIDE_N  = 1,
  parameter bit          HAS_FIX = 1'b0,
  localparam int unsigned PW     = (SIDE_N > 0) ? SIDE_N : 1
) (
  input  logic          path_i,
  input  logic [PW-1:0] side_i,
  input  logic          edge_i,
  input  logic          fix_i,
  output logic          out_o
);
  logic parity;

  if (SIDE_N > 0) begin : g_side
    assign parity = path_i ^ (^side_i);
  end else begin : g_noside
    logic unused_side;
    assign unused_side = ^side_i;
    assign parity = path_i;
  end

  if (HAS_FIX) begin : g_fix
    assign out_o = stage_eval(parity, edge_i, fix_i, 1'b1);
  end else begin : g_nofix
    logic unused_fix;
    assign unused_fix = fix_i;
    assign out_o = stage_eval(parity, edge_i, 1'b0, 1'b0);
  end
endmodule

// File: rtl/replica_capture.sv
module replica_capture (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic path_i,
  input  logic check_i,
  input  logic expect_i,
  input  logic clr_i,
  output logic sink_o,
  output logic err_o
);
  logic match;
  logic fault;

  assign match = ~(sink_o ^ expect_i);
  assign fault = check_i & ~match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sink_o <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      sink_o <= path_i;
      if (clr_i) err_o <= 1'b0;
      else       err_o <= err_o | fault;
    end
  end
endmodule

// File: rtl/path_replica.sv
module path_replica #(
  parameter int unsigned           NUM_STAGES = 3,
  parameter int unsigned           LUT_K      = 4,
  parameter logic [NUM_STAGES-1:0] FIX_EN     = 'b010,
  localparam int unsigned SIDE_N = (LUT_K > 3) ? LUT_K - 3 : 0,
  localparam int unsigned SIDE_W = (SIDE_N > 0) ? NUM_STAGES * SIDE_N : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  launch_i,
  input  logic [SIDE_W-1:0]     side_i,
  input  logic [NUM_STAGES-1:0] edge_i,
  input  logic [NUM_STAGES-1:0] fix_i,
  input  logic                  check_i,
  input  logic                  expect_i,
  input  logic                  clr_i,
  output logic                  sink_o,
  output logic                  err_o
);
  localparam int unsigned PW = (SIDE_N > 0) ? SIDE_N : 1;

  logic [NUM_STAGES:0] node;
  logic                launch_q;

  replica_launch u_launch (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (launch_i),
    .q_o   (launch_q)
  );

  assign node[0] = launch_q;

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
    logic [PW-1:0] side_s;
    if (SIDE_N > 0) begin : g_sl
      assign side_s = side_i[s*SIDE_N +: PW];
    end else begin : g_zero
      assign side_s = side_i[0];
    end

    replica_stage #(
      .SIDE_N (SIDE_N),
      .HAS_FIX(FIX_EN[s])
    ) u_stage (
      .path_i(node[s]),
      .side_i(side_s),
      .edge_i(edge_i[s]),
      .fix_i (fix_i[s]),
      .out_o (node[s+1])
    );
  end

  replica_capture u_capture (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .path_i  (node[NUM_STAGES]),
    .check_i (check_i),
    .expect_i(expect_i),
    .clr_i   (clr_i),
    .sink_o  (sink_o),
    .err_o   (err_o)
  );
endmodule

// File: rtl/path_replica_chk.sv
module path_replica_chk #(
  parameter int unsigned           NUM_STAGES = 3,
  parameter int unsigned           SIDE_W     = 3,
  parameter logic [NUM_STAGES-1:0] FIX_EN     = 'b010
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  launch_q,
  input logic [SIDE_W-1:0]     side_i,
  input logic [NUM_STAGES-1:0] edge_i,
  input logic [NUM_STAGES-1:0] fix_i,
  input logic                  check_i,
  input logic                  expect_i,
  input logic                  clr_i,
  input logic                  sink_o,
  input logic                  err_o
);
  logic [1:0] armed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             armed_q <= 2'd0;
    else if (armed_q != 2'd2) armed_q <= armed_q + 2'd1;
  end

  AST_ERR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    check_i && !clr_i && (sink_o != expect_i) |=> err_o); // R8

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o && !clr_i |=> err_o); // R9

  AST_ERR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !err_o); // R10

  AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !err_o && !(check_i && (sink_o != expect_i)) |=> !err_o); // R11

  AST_EDGE_INVERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q == 2'd2) && ((fix_i & FIX_EN) == '0) && $stable(fix_i) &&
    $stable(side_i) && $stable(launch_q) &&
    ($countones(edge_i ^ $past(edge_i)) == 1)
    |=> (sink_o != $past(sink_o))); // R4

  AST_FIX_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q == 2'd2) && ((fix_i & FIX_EN) != '0) && $stable(fix_i) &&
    $stable(side_i) && $stable(edge_i)
    |=> $stable(sink_o)); // R5
endmodule

bind path_replica path_replica_chk #(
  .NUM_STAGES(NUM_STAGES),
  .SIDE_W    (SIDE_W),
  .FIX_EN    (FIX_EN)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .launch_q(launch_q),
  .side_i  (side_i),
  .edge_i  (edge_i),
  .fix_i   (fix_i),
  .check_i (check_i),
  .expect_i(expect_i),
  .clr_i   (clr_i),
  .sink_o  (sink_o),
  .err_o   (err_o)
);

// File: tb/path_replica_tb.sv
module path_replica_tb;
  localparam int unsigned NS = 3;
  localparam logic [NS-1:0] FEN = 3'b010;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic launch_i = 1'b0;
  logic [NS-1:0] side_i = '0;
  logic [NS-1:0] edge_i = '0;
  logic [NS-1:0] fix_i = '0;
  logic check_i = 1'b0, expect_i = 1'b0, clr_i = 1'b0;
  logic sink_o, err_o;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  path_replica u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .launch_i(launch_i), .side_i(side_i),
    .edge_i(edge_i), .fix_i(fix_i), .check_i(check_i), .expect_i(expect_i),
    .clr_i(clr_i), .sink_o(sink_o), .err_o(err_o)
  );

  function automatic logic model(logic l, logic [NS-1:0] sd, logic [NS-1:0] ed,
                                 logic [NS-1:0] fx);
    logic v = l;
    for (int s = 0; s < NS; s++) begin
      v = v ^ sd[s] ^ ed[s];
      if (FEN[s] && fx[s]) v = 1'b1;
    end
    return v;
  endfunction

  task automatic chk(logic got, logic exp, string tag);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic apply(logic l, logic [NS-1:0] sd, logic [NS-1:0] ed, logic [NS-1:0] fx);
    launch_i = l; side_i = sd; edge_i = ed; fix_i = fx;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic strobe(logic exp, logic chk_en, logic clr);
    expect_i = exp; check_i = chk_en; clr_i = clr;
    @(negedge clk);
    check_i = 1'b0; clr_i = 1'b0;
  endtask

  task automatic t_reset;
    launch_i = 1'b1; edge_i = 3'b111;
    repeat (3) @(negedge clk);
    chk(sink_o, 1'b0, "R1 sink in reset");
    chk(err_o, 1'b0, "R1 err in reset");
    rst_ni = 1'b1;
    launch_i = 1'b0; edge_i = '0;
    @(negedge clk);
    chk(sink_o, 1'b0, "R1 sink after release (launch flop was 0)");
    chk(err_o, 1'b0, "R1 err after release");
  endtask

  task automatic t_parity;
    for (int c = 0; c < 128; c++) begin
      logic [6:0] v = c[6:0];
      apply(v[0], v[3:1], v[6:4], '0);
      chk(sink_o, model(v[0], v[3:1], v[6:4], '0), $sformatf("R3 parity combo %0d", c));
    end
  endtask

  task automatic t_latency;
    apply(1'b0, '0, '0, '0);
    chk(sink_o, 1'b0, "R7 baseline");
    launch_i = 1'b1;
    @(negedge clk);
    chk(sink_o, 1'b0, "R2 no change after first edge");
    @(negedge clk);
    chk(sink_o, 1'b1, "R7 new value after second edge");
  endtask

  task automatic t_edge;
    for (int s = 0; s < NS; s++) begin
      logic [NS-1:0] ed = 3'b001;
      apply(1'b1, 3'b010, ed, '0);
      chk(sink_o, model(1'b1, 3'b010, ed, '0), "R4 base");
      edge_i = ed ^ (3'b001 << s);
      @(negedge clk);
      chk(sink_o, ~model(1'b1, 3'b010, ed, '0), $sformatf("R4 edge bit %0d inverts", s));
    end
  endtask

  task automatic t_fix_block;
    // stage 1 fixed: output = 1 ^ side[2] ^ edge[2]
    for (int c = 0; c < 16; c++) begin
      logic [3:0] v = c[3:0];
      apply(v[0], {1'b1, v[2], v[1]}, {1'b0, v[1], v[3]}, 3'b010);
      chk(sink_o, 1'b0, $sformatf("R5 fix blocks upstream combo %0d", c));
    end
    apply(1'b0, 3'b000, 3'b000, 3'b010);
    chk(sink_o, 1'b1, "R5 forced stage feeds downstream parity");
  endtask

  task automatic t_fix_ignored;
    for (int c = 0; c < 8; c++) begin
      logic [2:0] v = c[2:0];
      apply(v[0], {v[1], 1'b0, v[2]}, {1'b0, v[2], v[1]}, 3'b101);
      chk(sink_o, model(v[0], {v[1], 1'b0, v[2]}, {1'b0, v[2], v[1]}, 3'b000),
          $sformatf("R6 fix on non-fixable stages ignored %0d", c));
    end
  endtask

  task automatic t_compare;
    apply(1'b1, '0, '0, '0);        // sink = 1
    strobe(1'b1, 1'b1, 1'b0);
    chk(err_o, 1'b0, "R11 match gives no error");
    strobe(1'b0, 1'b0, 1'b0);
    chk(err_o, 1'b0, "R11 mismatch without check ignored");
    strobe(1'b0, 1'b1, 1'b0);
    chk(err_o, 1'b1, "R8 mismatch sets error");
    for (int i = 0; i < 3; i++) begin
      strobe(1'b1, 1'b1, 1'b0);
      chk(err_o, 1'b1, "R9 error sticky over matching checks");
    end
    strobe(1'b0, 1'b1, 1'b1);
    chk(err_o, 1'b0, "R10 clear wins over mismatch");
    strobe(1'b1, 1'b1, 1'b0);
    chk(err_o, 1'b0, "R10 stays clear after clear");
    apply(1'b0, '0, '0, '0);        // sink = 0
    strobe(1'b1, 1'b1, 1'b0);
    chk(err_o, 1'b1, "R8 mismatch on zero sink sets error");
    strobe(1'b0, 1'b0, 1'b1);
    chk(err_o, 1'b0, "R10 clear alone");
  endtask

  initial begin
    t_reset();
    t_parity();
    t_latency();
    t_edge();
    t_fix_block();
    t_fix_ignored();
    t_compare();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule